// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU and the memories of a small handheld console. It takes a 16-bit address together with a read or write request and picks the region the address belongs to. The regions are cartridge ROM (fixed and banked), video RAM, external RAM, work RAM with its echo, the sprite attribute table (OAM), an unusable hole, I/O registers, high RAM and the interrupt-enable register. For the chosen region it raises a one-hot strobe, and it returns that region's read data to the CPU through a register one cycle later. The memory arrays, the cartridge bank controller and the video controller all live outside the block. The block reaches them through a shared address, write-enable and write-data bus and through one read-data input per region.

Two kinds of lockout sit on top of the decode. The first comes from the current video mode. Video RAM cannot be reached during pixel transfer, and OAM can be reached only in the blanking modes. The second comes from an active OAM DMA transfer. The address space is cut into eight 8 KB groups, and each group is tied to a bus. The CPU is shut out of any group on the DMA source's bus, unless that bus is the CPU-internal one, and it is always shut out of OAM. A blocked read returns 0xFF and a blocked write is dropped. The block also holds the 3-bit work-RAM bank register.

Top module: `bank_map_dec`

## Requirements
- R1: While req_i is high, sel_o has at most one bit set, and sel_o is zero while req_i is low. The bit positions are: 0 fixed ROM read (0x0000-0x3FFF), 1 banked ROM read (0x4000-0x7FFF), 2 video RAM (0x8000-0x9FFF), 3 external RAM (0xA000-0xBFFF), 4 work RAM (0xC000-0xFDFF), 5 OAM (0xFE00-0xFE9F), 6 I/O (0xFF00-0xFF7F except the bank register), 7 high RAM (0xFF80-0xFFFE), 8 interrupt enable (0xFFFF), 9 bank-controller write.
- R2: A read that is not blocked loads rdata_o at the next rising clock edge with the read-data input of the selected region. rdata_o keeps its value in every cycle that has no read request.
- R3: A write to 0x0000-0x7FFF raises only sel_o bit 9 and never sel_o bits 0 or 1.
- R4: While vid_mode_i is 3, video RAM accesses raise no strobe, reads return 0xFF and writes are dropped. In modes 0 to 2, video RAM is reachable.
- R5: OAM is reachable only while vid_mode_i is 0 or 1. In modes 2 and 3, OAM reads return 0xFF and writes raise no strobe.
- R6: Reads of 0xFEA0-0xFEFF raise no strobe and return 0xFF.
- R7: A write to 0xFF70 stores wdata_i[2:0] in the bank register, and a read of 0xFF70 returns {5'b11111, stored bits}. The effective bank is the stored value, except that a stored 0 gives bank 1. wram_addr_o is {bank, addr[11:0]}, where bank is 0 when addr_i[12] is 0 and the effective bank when addr_i[12] is 1.
- R8: 0xE000-0xFDFF mirrors work RAM. It raises sel_o bit 4 with the same wram_addr_o as the address 0x2000 lower.
- R9: While dma_active_i is high, an access is blocked when its group (addr[15:13]) is on the same bus as the DMA source group dma_grp_i and that bus is not CPU-internal. Groups 0-3 and 5 are on the main bus, group 4 is on the video bus and group 7 is CPU-internal. Group 6 is on the work-RAM bus when model_i is 1 and on the main bus when model_i is 0.
- R10: While dma_active_i is high, any access to 0xFE00-0xFE9F is blocked, whatever the source group.
- R11: After reset, rdata_o is 0xFF and the bank register holds 0, so its readback is 0xF8.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Registered read data |
| model_i | input | 1 | 1 = enhanced model bus map |
| vid_mode_i | input | 2 | Current video mode |
| dma_active_i | input | 1 | OAM DMA in progress |
| dma_grp_i | input | 3 | Address bits [15:13] of the DMA source |
| sel_o | output | 10 | One-hot region strobes |
| reg_addr_o | output | 16 | Address to the regions |
| reg_we_o | output | 1 | Write enable to the regions |
| reg_wdata_o | output | 8 | Write data to the regions |
| wram_addr_o | output | 15 | Banked work-RAM address |
| rom_rdata_i | input | 8 | ROM read data |
| vram_rdata_i | input | 8 | Video RAM read data |
| xram_rdata_i | input | 8 | External RAM read data |
| wram_rdata_i | input | 8 | Work RAM read data |
| oam_rdata_i | input | 8 | OAM read data |
| io_rdata_i | input | 8 | I/O read data |
| hram_rdata_i | input | 8 | High RAM read data |
| ie_rdata_i | input | 8 | Interrupt-enable read data |

## Verification
The strobes and wram_addr_o are combinational from the request, so they are due within the request cycle itself. The bench samples them 1 ns after it drives the inputs on the falling edge. rdata_o and the bank register change on the rising edge that ends the request cycle. The bench samples them at the following falling edge, and a bank write is read back or used only in a later request. Every region read-data input carries a distinct constant, so a wrong mux choice or a missing 0xFF substitution shows up as a wrong byte in that one sample.

// File: rtl/bmd_pkg.sv
`timescale 1ns/1ps
package bmd_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int GRP_W      = 3;
  localparam int WRAM_OFF_W = 12;

  typedef enum logic [1:0] {
    BUS_MAIN = 2'd0,
    BUS_VID  = 2'd1,
    BUS_WRK  = 2'd2,
    BUS_CPU  = 2'd3
  } bus_e;

  // strobe positions, decoded by the region ports
  localparam int RG_ROM0 = 0;
  localparam int RG_ROMX = 1;
  localparam int RG_VRAM = 2;
  localparam int RG_XRAM = 3;
  localparam int RG_WRAM = 4;
  localparam int RG_OAM  = 5;
  localparam int RG_IO   = 6;
  localparam int RG_HRAM = 7;
  localparam int RG_IE   = 8;
  localparam int RG_CTL  = 9;
  localparam int RG_N    = 10;

  function automatic bus_e grp_bus(input int g, input logic ext);
    if (g == 4)             return BUS_VID;
    else if (g == 7)        return BUS_CPU;
    else if (g == 6 && ext) return BUS_WRK;
    else                    return BUS_MAIN;
  endfunction
endpackage

// File: rtl/bmd_bus_lock.sv
`timescale 1ns/1ps
module bmd_bus_lock
  import bmd_pkg::*;
#(
  parameter int G_W = GRP_W
) (
  input  logic           model_i,
  input  logic           dma_active_i,
  input  logic [G_W-1:0] dma_grp_i,
  input  logic [G_W-1:0] cpu_grp_i,
  input  logic           oam_hit_i,
  output logic           lock_o
);
  localparam int G_N = 1 << G_W;

  bus_e tbl_base [G_N];
  bus_e tbl_ext  [G_N];

  for (genvar g = 0; g < G_N; g++) begin : g_tbl
    assign tbl_base[g] = grp_bus(g, 1'b0);
    assign tbl_ext[g]  = grp_bus(g, 1'b1);
  end

  bus_e dma_bus, cpu_bus;
  assign dma_bus = model_i ? tbl_ext[dma_grp_i] : tbl_base[dma_grp_i];
  assign cpu_bus = model_i ? tbl_ext[cpu_grp_i] : tbl_base[cpu_grp_i];

  assign lock_o = dma_active_i &&
                  (oam_hit_i || (dma_bus != BUS_CPU && dma_bus == cpu_bus));
endmodule

// File: rtl/bmd_region_dec.sv
`timescale 1ns/1ps
module bmd_region_dec
  import bmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WBANK_ADDR = 16'hFF70
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic [RG_N-1:0]   raw_o,
  output logic              vram_o,
  output logic              oam_o,
  output logic              wbank_o
);
  always_comb begin
    raw_o   = '0;
    vram_o  = 1'b0;
    oam_o   = 1'b0;
    wbank_o = 1'b0;
    if (!addr_i[15]) begin
      if (we_i)           raw_o[RG_CTL]  = 1'b1;
      else if (addr_i[14]) raw_o[RG_ROMX] = 1'b1;
      else                raw_o[RG_ROM0] = 1'b1;
    end else begin
      unique case (addr_i[14:13])
        2'd0: begin
          vram_o         = 1'b1;
          raw_o[RG_VRAM] = 1'b1;
        end
        2'd1: raw_o[RG_XRAM] = 1'b1;
        2'd2: raw_o[RG_WRAM] = 1'b1;
        default: begin
          if (addr_i < 16'hFE00) raw_o[RG_WRAM] = 1'b1;
          else if (addr_i < 16'hFEA0) begin
            oam_o         = 1'b1;
            raw_o[RG_OAM] = 1'b1;
          end
          else if (addr_i < 16'hFF00) raw_o = '0;
          else if (addr_i == WBANK_ADDR) wbank_o = 1'b1;
          else if (addr_i < 16'hFF80) raw_o[RG_IO] = 1'b1;
          else if (addr_i != 16'hFFFF) raw_o[RG_HRAM] = 1'b1;
          else raw_o[RG_IE] = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bmd_wbank.sv
`timescale 1ns/1ps
module bmd_wbank #(
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   raw_o <= '0;
    else if (wr_i) raw_o <= wdata_i;
  end

  assign eff_o = (raw_o == '0) ? BANK_W'(1) : raw_o;
endmodule

// File: rtl/bank_map_dec.sv
`timescale 1ns/1ps
module bank_map_dec
  import bmd_pkg::*;
#(
  parameter int                BANK_W     = 3,
  parameter logic [ADDR_W-1:0] WBANK_ADDR = 16'hFF70
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic                       model_i,
  input  logic [1:0]                 vid_mode_i,
  input  logic                       dma_active_i,
  input  logic [GRP_W-1:0]           dma_grp_i,
  output logic [RG_N-1:0]            sel_o,
  output logic [ADDR_W-1:0]          reg_addr_o,
  output logic                       reg_we_o,
  output logic [DATA_W-1:0]          reg_wdata_o,
  output logic [BANK_W+WRAM_OFF_W-1:0] wram_addr_o,
  input  logic [DATA_W-1:0]          rom_rdata_i,
  input  logic [DATA_W-1:0]          vram_rdata_i,
  input  logic [DATA_W-1:0]          xram_rdata_i,
  input  logic [DATA_W-1:0]          wram_rdata_i,
  input  logic [DATA_W-1:0]          oam_rdata_i,
  input  logic [DATA_W-1:0]          io_rdata_i,
  input  logic [DATA_W-1:0]          hram_rdata_i,
  input  logic [DATA_W-1:0]          ie_rdata_i
);
  localparam logic [DATA_W-1:0] OPEN_BUS = '1;
  localparam int                PAD_W    = DATA_W - BANK_W;

  logic [RG_N-1:0]   raw;
  logic              vram_hit, oam_hit, wbank_hit;
  logic              dma_lock, mode_lock, allow;
  logic [BANK_W-1:0] bank_raw, bank_eff;
  logic [DATA_W-1:0] rd_next;

  bmd_region_dec #(.WBANK_ADDR(WBANK_ADDR)) u_dec (
    .addr_i  (addr_i),
    .we_i    (we_i),
    .raw_o   (raw),
    .vram_o  (vram_hit),
    .oam_o   (oam_hit),
    .wbank_o (wbank_hit)
  );

  bmd_bus_lock #(.G_W(GRP_W)) u_lock (
    .model_i      (model_i),
    .dma_active_i (dma_active_i),
    .dma_grp_i    (dma_grp_i),
    .cpu_grp_i    (addr_i[ADDR_W-1 -: GRP_W]),
    .oam_hit_i    (oam_hit),
    .lock_o       (dma_lock)
  );

  // pixel transfer = 3, OAM scan = 2
  assign mode_lock = (vram_hit && vid_mode_i == 2'd3) || (oam_hit && vid_mode_i[1]);
  assign allow     = req_i && !dma_lock && !mode_lock;
  assign sel_o     = allow ? raw : '0;

  bmd_wbank #(.BANK_W(BANK_W)) u_wbank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (allow && we_i && wbank_hit),
    .wdata_i (wdata_i[BANK_W-1:0]),
    .raw_o   (bank_raw),
    .eff_o   (bank_eff)
  );

  assign wram_addr_o = {(addr_i[WRAM_OFF_W] ? bank_eff : BANK_W'(0)),
                        addr_i[WRAM_OFF_W-1:0]};
  assign reg_addr_o  = addr_i;
  assign reg_we_o    = we_i;
  assign reg_wdata_o = wdata_i;

  always_comb begin
    rd_next = OPEN_BUS;
    if (allow) begin
      if (wbank_hit)                           rd_next = {{PAD_W{1'b1}}, bank_raw};
      else if (raw[RG_ROM0] || raw[RG_ROMX])   rd_next = rom_rdata_i;
      else if (raw[RG_VRAM])                   rd_next = vram_rdata_i;
      else if (raw[RG_XRAM])                   rd_next = xram_rdata_i;
      else if (raw[RG_WRAM])                   rd_next = wram_rdata_i;
      else if (raw[RG_OAM])                    rd_next = oam_rdata_i;
      else if (raw[RG_IO])                     rd_next = io_rdata_i;
      else if (raw[RG_HRAM])                   rd_next = hram_rdata_i;
      else if (raw[RG_IE])                     rd_next = ie_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= OPEN_BUS;
    else if (req_i && !we_i)  rdata_o <= rd_next;
  end
endmodule

// File: rtl/bmd_chk.sv
`timescale 1ns/1ps
module bmd_chk
  import bmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [1:0]        vid_mode_i,
  input logic              dma_active_i,
  input logic [RG_N-1:0]   sel_o,
  input logic [14:0]       wram_addr_o
);
  // R1
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R1
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> sel_o == '0);

  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R3
  rom_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !addr_i[15]) |-> (!sel_o[RG_ROM0] && !sel_o[RG_ROMX]));

  // R4
  vram_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_mode_i == 2'd3 |-> !sel_o[RG_VRAM]);

  // R5
  oam_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_mode_i[1] |-> !sel_o[RG_OAM]);

  // R6
  hole_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i >= 16'hFEA0 && addr_i < 16'hFF00) |=> rdata_o == 8'hFF);

  // R7
  bank_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o[RG_WRAM] && addr_i[12]) |-> wram_addr_o[14:12] != 3'd0);

  // R10
  dma_oam_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_active_i |-> !sel_o[RG_OAM]);
endmodule

bind bank_map_dec bmd_chk u_chk (.*);

// File: tb/sim_bank_map_dec.sv
`timescale 1ns/1ps
module sim_bank_map_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        model = 1'b0;
  logic [1:0]  vmode = 2'd0;
  logic        dma = 1'b0;
  logic [2:0]  dgrp = 3'd0;
  logic [9:0]  sel;
  logic [15:0] raddr;
  logic        rwe;
  logic [7:0]  rwd;
  logic [14:0] waddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bank_map_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .model_i(model), .vid_mode_i(vmode),
    .dma_active_i(dma), .dma_grp_i(dgrp), .sel_o(sel), .reg_addr_o(raddr),
    .reg_we_o(rwe), .reg_wdata_o(rwd), .wram_addr_o(waddr),
    .rom_rdata_i(8'h11), .vram_rdata_i(8'h22), .xram_rdata_i(8'h33),
    .wram_rdata_i(8'h44), .oam_rdata_i(8'h55), .io_rdata_i(8'h66),
    .hram_rdata_i(8'h77), .ie_rdata_i(8'h88)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one request cycle; strobes sampled 1 ns in, rdata at the next falling edge
  task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d,
                        output logic [9:0] s, output logic [14:0] wa, output logic [7:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    s = sel; wa = waddr;
    @(negedge clk);
    rd = rdata;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input int exp_sel, input int exp_rd);
    logic [9:0] s; logic [14:0] wa; logic [7:0] rd;
    access(a, 1'b0, 8'h00, s, wa, rd);
    chk({tag, " sel"}, s, exp_sel);
    chk({tag, " rdata"}, rd, exp_rd);
  endtask

  task automatic wr_chk(input string tag, input logic [15:0] a, input logic [7:0] d, input int exp_sel);
    logic [9:0] s; logic [14:0] wa; logic [7:0] rd;
    access(a, 1'b1, d, s, wa, rd);
    chk({tag, " sel"}, s, exp_sel);
  endtask

  task automatic wa_chk(input string tag, input logic [15:0] a, input int exp_wa);
    logic [9:0] s; logic [14:0] wa; logic [7:0] rd;
    access(a, 1'b0, 8'h00, s, wa, rd);
    chk({tag, " sel"}, s, 10'h010);
    chk({tag, " wram_addr"}, wa, exp_wa);
  endtask

  task automatic t_reset();
    chk("R11 rdata after reset", rdata, 8'hFF);
    chk("R1 idle sel", sel, 0);
    rd_chk("R11 bank readback", 16'hFF70, 0, 8'hF8);
  endtask

  task automatic t_regions();
    vmode = 2'd0;
    rd_chk("R1 fixed rom", 16'h0123, 10'h001, 8'h11);
    rd_chk("R1 banked rom", 16'h4567, 10'h002, 8'h11);
    rd_chk("R1 vram", 16'h8000, 10'h004, 8'h22);
    rd_chk("R1 xram", 16'hA100, 10'h008, 8'h33);
    rd_chk("R1 wram", 16'hC010, 10'h010, 8'h44);
    rd_chk("R1 oam", 16'hFE10, 10'h020, 8'h55);
    rd_chk("R1 io", 16'hFF05, 10'h040, 8'h66);
    rd_chk("R1 hram", 16'hFF90, 10'h080, 8'h77);
    rd_chk("R2 ie", 16'hFFFF, 10'h100, 8'h88);
    wr_chk("R2 hram write", 16'hFF81, 8'h5A, 10'h080);
    chk("R2 rdata held over write", rdata, 8'h88);
  endtask

  task automatic t_rom_write();
    wr_chk("R3 write 0x2000", 16'h2000, 8'h03, 10'h200);
    wr_chk("R3 write 0x7FFF", 16'h7FFF, 8'h01, 10'h200);
  endtask

  task automatic t_vram_mode();
    vmode = 2'd3;
    rd_chk("R4 vram read mode3", 16'h9000, 0, 8'hFF);
    wr_chk("R4 vram write mode3", 16'h9000, 8'h12, 0);
    vmode = 2'd2;
    rd_chk("R4 vram read mode2", 16'h9000, 10'h004, 8'h22);
    vmode = 2'd0;
  endtask

  task automatic t_oam_mode();
    vmode = 2'd2;
    rd_chk("R5 oam read mode2", 16'hFE00, 0, 8'hFF);
    vmode = 2'd3;
    wr_chk("R5 oam write mode3", 16'hFE40, 8'h9A, 0);
    vmode = 2'd1;
    rd_chk("R5 oam read mode1", 16'hFE9F, 10'h020, 8'h55);
    vmode = 2'd0;
  endtask

  task automatic t_hole();
    rd_chk("R6 hole low", 16'hFEA0, 0, 8'hFF);
    rd_chk("R6 hole high", 16'hFEFF, 0, 8'hFF);
  endtask

  task automatic t_wbank();
    wr_chk("R7 bank write 0", 16'hFF70, 8'h00, 0);
    wa_chk("R7 bank0 maps 1", 16'hD123, 15'h1123);
    wr_chk("R7 bank write 5", 16'hFF70, 8'h0D, 0);
    wa_chk("R7 bank5", 16'hD456, 15'h5456);
    wa_chk("R7 fixed half", 16'hC456, 15'h0456);
    rd_chk("R7 bank readback", 16'hFF70, 0, 8'hFD);
    wa_chk("R8 echo banked", 16'hF456, 15'h5456);
    wa_chk("R8 echo fixed", 16'hE456, 15'h0456);
    wr_chk("R7 bank write 8", 16'hFF70, 8'h08, 0);
    wa_chk("R7 masked to 1", 16'hD000, 15'h1000);
  endtask

  task automatic t_dma_bus();
    dma = 1'b1;
    model = 1'b0; dgrp = 3'd0;
    rd_chk("R9 main rom blocked", 16'h4000, 0, 8'hFF);
    rd_chk("R9 main xram blocked", 16'hA000, 0, 8'hFF);
    rd_chk("R9 base wram blocked", 16'hC000, 0, 8'hFF);
    rd_chk("R9 vram free", 16'h8000, 10'h004, 8'h22);
    model = 1'b1;
    rd_chk("R9 enhanced wram free", 16'hC000, 10'h010, 8'h44);
    dgrp = 3'd4;
    rd_chk("R9 vram src blocks vram", 16'h8000, 0, 8'hFF);
    rd_chk("R9 vram src rom free", 16'h0100, 10'h001, 8'h11);
    dgrp = 3'd6;
    rd_chk("R9 wram src blocks wram", 16'hC000, 0, 8'hFF);
    rd_chk("R9 echo on cpu bus", 16'hE000, 10'h010, 8'h44);
    dgrp = 3'd7;
    rd_chk("R9 cpu src hram free", 16'hFF80, 10'h080, 8'h77);
    dma = 1'b0; model = 1'b0; dgrp = 3'd0;
  endtask

  task automatic t_dma_oam();
    dma = 1'b1; dgrp = 3'd4; vmode = 2'd0;
    rd_chk("R10 oam read in dma", 16'hFE00, 0, 8'hFF);
    wr_chk("R10 oam write in dma", 16'hFE50, 8'h33, 0);
    dma = 1'b0;
    rd_chk("R10 oam after dma", 16'hFE50, 10'h020, 8'h55);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regions();
    t_rom_write();
    t_vram_mode();
    t_oam_mode();
    t_hole();
    t_wbank();
    t_dma_bus();
    t_dma_oam();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule